// File: doc/BRIEF.md
# Edge-Latched Single-Bit Static RAM

This block models a small static memory whose cycles are framed by an active-low enable strobe rather than by a plain clocked port. The block samples all of its control pins with a fast system clock. The strobe's falling edge starts a cycle and captures the address. While the strobe stays low, the addressed word is presented on the output. When the strobe rises, the output value is frozen in an output latch, so it can still be placed on a bus later by re-selecting the part.

Two active-low selects must both be low for the output to drive. A write happens during a window in which the strobe, the write enable and both selects are all low at once. The word is stored when that window closes. Because the output turns off as soon as write enable drops, the data input and output can share one wire.

Top module: `edge_latched_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. Each address keeps its own value, independent of writes to other addresses.
- R2: The address is taken from `addr` at the first clock edge that sees `chipEnN` low after it was high. Changes to `addr` later in the same strobe-low period have no effect on the data read or on the location written.
- R3: If `selAN` or `selBN` is high at a clock edge, `qEnable` is low after that edge.
- R4: A read cycle works as follows. `chipEnN` falls with both selects low and `wrEnN` high. From the second clock edge after the fall, `qEnable` is high and `qOut` carries the word at the captured address.
- R5: After `chipEnN` rises, `qOut` keeps the last value it read. If both selects are low while `chipEnN` is high, `qEnable` is high with that held value. This applies again after the selects are raised and lowered once more.
- R6: The write window is open while `chipEnN`, `wrEnN`, `selAN` and `selBN` are all low. It closes at the first of these four that goes high, and the word is stored at that moment. Changes to `dataIn` after the window has closed are not stored.
- R7: `dataIn` may change several times while the window is open. The value sampled at the last clock edge before the window closes is the one stored.
- R8: `wrEnN` may stay low across several strobe periods. Each strobe-low period then writes `dataIn` to its own captured address.
- R9: If `wrEnN` is low while `chipEnN` is low, `qEnable` is low after that clock edge.
- R10: A clock edge with `rstN` low clears the address register and the output latch, and leaves `qEnable` low. `qEnable` stays low with both selects low and the strobe high until a new read. The array contents survive the reset.
- R11: In a combined cycle, `wrEnN` is high first and drops later in the same strobe-low period. `qOut` shows the old word before `wrEnN` falls and still holds it after the strobe rises. The new word is stored when the window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEnN | input | 1 | Active-low cycle strobe |
| wrEnN | input | 1 | Active-low write enable |
| selAN | input | 1 | Active-low select, first of two |
| selBN | input | 1 | Active-low select, second of two |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data |
| qOut | output | DATA_W | Read data, meaningful when qEnable is high |
| qEnable | output | 1 | Output driver enable; low means high impedance |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=1. This gives a 16-word array, in which the lowest and highest addresses and a range of middle ones are written, read back and overwritten in a few hundred cycles. The small depth also makes it cheap to show that a reset leaves stored words untouched. The single-bit width means each window-closing test can be set up so that the stored bit is the opposite of what the location held before. A dropped or misplaced commit therefore shows up as a wrong bit.

// File: rtl/edge_ram_pkg.sv
package edge_ram_pkg;

  // Strobes from the control side to the datapath, one per clock.
  typedef struct packed {
    logic capAddr;   // strobe fall seen: take the address
    logic trackOut;  // strobe low and cycle live: output follows array
    logic holdData;  // write window open: sample write data
    logic commit;    // write window just closed: store held data
  } ramStrobeT;

endpackage

// File: rtl/edge_ram_ctrl.sv
module edge_ram_ctrl
  import edge_ram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipEnN,
  input  logic      wrEnN,
  input  logic      selAN,
  input  logic      selBN,
  output ramStrobeT strobe,
  output logic      qEnable
);

  logic enPrev;     // strobe level at the previous edge
  logic cycleLive;  // address captured, strobe still low
  logic winPrev;    // write window was open at the previous edge
  logic outValid;   // the output latch holds a value read since reset
  logic qEnReg;

  logic eFall, eRise, selected, winNow;

  assign eFall    = enPrev & ~chipEnN;
  assign eRise    = ~enPrev & chipEnN;
  assign selected = ~selAN & ~selBN;
  assign winNow   = cycleLive & ~chipEnN & ~wrEnN & selected;

  always_comb begin
    strobe.capAddr  = eFall;
    strobe.trackOut = cycleLive & ~chipEnN;
    strobe.holdData = winNow;
    strobe.commit   = winPrev & ~winNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev    <= 1'b1;
      cycleLive <= 1'b0;
      winPrev   <= 1'b0;
      outValid  <= 1'b0;
      qEnReg    <= 1'b0;
    end else begin
      enPrev  <= chipEnN;
      winPrev <= winNow;
      if (eFall)      cycleLive <= 1'b1;
      else if (eRise) cycleLive <= 1'b0;
      if (strobe.trackOut) outValid <= 1'b1;
      // While the strobe is low the driver follows the write enable.
      // While it is high the driver shows the held value.
      qEnReg <= selected & (chipEnN ? outValid : (wrEnN & cycleLive));
    end
  end

  assign qEnable = qEnReg;

  // R3: a raised select turns the driver off at the next edge
  p_deselect_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selAN | selBN) |=> !qEnable);

  // R9: write enable low inside a strobe period turns the driver off
  p_write_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !wrEnN) |=> !qEnable);

  // R10: reset leaves the driver off
  p_reset_off_r10: assert property (@(posedge clk)
    !rstN |=> !qEnable);

  // R6: a commit is a single pulse per window
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit);

endmodule

// File: rtl/edge_ram_datapath.sv
module edge_ram_datapath
  import edge_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobeT         strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] outLatch;
  logic [DATA_W-1:0] dHold;
  logic [DATA_W-1:0] rdWord;

  assign rdWord = memArr[addrReg];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      outLatch <= '0;
      dHold    <= '0;
    end else begin
      if (strobe.capAddr)  addrReg  <= addrIn;
      if (strobe.trackOut) outLatch <= rdWord;
      if (strobe.holdData) dHold    <= dataIn;
    end
  end

  // The array has no reset, so its contents survive one.
  always_ff @(posedge clk) begin
    if (rstN && strobe.commit) memArr[addrReg] <= dHold;
  end

  assign qData = outLatch;

  // R2: the address register moves only on a strobe fall
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capAddr |=> $stable(addrReg));

  // R5: outside a live strobe period the output latch is frozen
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.trackOut |=> $stable(outLatch));

  // R6: a commit leaves the held word at the captured address
  p_commit_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (memArr[$past(addrReg)] == $past(dHold)));

endmodule

// File: rtl/edge_latched_ram.sv
module edge_latched_ram
  import edge_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              wrEnN,
  input  logic              selAN,
  input  logic              selBN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] qOut,
  output logic              qEnable
);

  ramStrobeT strobe;

  edge_ram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .chipEnN (chipEnN),
    .wrEnN   (wrEnN),
    .selAN   (selAN),
    .selBN   (selBN),
    .strobe  (strobe),
    .qEnable (qEnable)
  );

  edge_ram_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addrIn (addr),
    .dataIn (dataIn),
    .qData  (qOut)
  );

endmodule

// File: tb/edge_latched_ram_tb.sv
module edge_latched_ram_tb;

  localparam int AW = 4;
  localparam int DW = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEnN = 1'b1, wrEnN = 1'b1, selAN = 1'b1, selBN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] qOut;
  logic qEnable;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [DW-1:0] refMem [1<<AW];

  always #2.5 clk = ~clk;

  edge_latched_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .wrEnN(wrEnN),
    .selAN(selAN), .selBN(selBN), .addr(addr), .dataIn(dataIn),
    .qOut(qOut), .qEnable(qEnable)
  );

  // Each entry: {write flag, address[3:0], data}.
  localparam logic [5:0] VEC [14] = '{
    6'b1_0000_1, 6'b1_1111_1, 6'b1_0101_0, 6'b1_1010_1,
    6'b1_0011_0, 6'b1_1100_1, 6'b0_0000_0, 6'b0_1111_0,
    6'b0_0101_0, 6'b0_1010_0, 6'b0_0011_0, 6'b0_1100_0,
    6'b1_1111_0, 6'b0_1111_0
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic writeCycle(input logic [AW-1:0] a, input logic [DW-1:0] d);
    chipEnN = 1'b0; wrEnN = 1'b1; selAN = 1'b0; selBN = 1'b0; addr = a;
    tick();
    wrEnN = 1'b0; dataIn = d;
    tick();
    chipEnN = 1'b1;
    tick();
    wrEnN = 1'b1; selAN = 1'b1; selBN = 1'b1;
    tick();
    refMem[a] = d;
  endtask

  task automatic readCycle(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    chipEnN = 1'b0; wrEnN = 1'b1; selAN = 1'b0; selBN = 1'b0; addr = a;
    tick();
    tick();
    chk({31'b0, qEnable}, 32'd1, {tag, " enable"});
    chk({31'b0, qOut}, {31'b0, exp}, {tag, " data"});
    chipEnN = 1'b1;
    tick();
    selAN = 1'b1; selBN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R10: reset state
    chk({31'b0, qEnable}, 32'd0, "R10 driver off in reset");
    rstN = 1'b1;
    tick();
    selAN = 1'b0; selBN = 1'b0;
    tick();
    chk({31'b0, qEnable}, 32'd0, "R10 no held value after reset");
    selAN = 1'b1; selBN = 1'b1;
    tick();

    // R1 / R4: table of writes and reads
    foreach (VEC[i]) begin
      if (VEC[i][5]) writeCycle(VEC[i][4:1], VEC[i][0]);
      else readCycle(VEC[i][4:1], refMem[VEC[i][4:1]], "R1 R4 table read");
    end

    // R2: address change mid-cycle is ignored (addr 0 holds 1, addr 5 holds 0)
    chipEnN = 1'b0; selAN = 1'b0; selBN = 1'b0; addr = 4'd0;
    tick(); tick();
    addr = 4'd5;
    tick(); tick();
    chk({31'b0, qOut}, 32'd1, "R2 late address ignored");
    // R3: either select raised turns the driver off
    selAN = 1'b1;
    tick();
    chk({31'b0, qEnable}, 32'd0, "R3 first select high");
    selAN = 1'b0;
    tick();
    chk({31'b0, qEnable}, 32'd1, "R3 reselected");
    selBN = 1'b1;
    tick();
    chk({31'b0, qEnable}, 32'd0, "R3 second select high");
    selBN = 1'b0;
    // R5: held value after the strobe rises, then again after reselect
    chipEnN = 1'b1;
    tick();
    chk({31'b0, qEnable}, 32'd1, "R5 held value driven");
    chk({31'b0, qOut}, 32'd1, "R5 held value");
    selAN = 1'b1; selBN = 1'b1;
    tick(); tick();
    selAN = 1'b0; selBN = 1'b0;
    tick();
    chk({31'b0, qEnable}, 32'd1, "R5 re-enabled");
    chk({31'b0, qOut}, 32'd1, "R5 re-enabled value");
    selAN = 1'b1; selBN = 1'b1;
    tick();

    // R6: window closed by a select; later data ignored (addr 5 holds 0)
    chipEnN = 1'b0; wrEnN = 1'b1; selAN = 1'b0; selBN = 1'b0; addr = 4'd5;
    tick();
    wrEnN = 1'b0; dataIn = 1'b1;
    tick();
    selAN = 1'b1;
    tick();
    dataIn = 1'b0;
    tick(); tick();
    chipEnN = 1'b1;
    tick();
    wrEnN = 1'b1; selBN = 1'b1;
    tick();
    readCycle(4'd5, 1'b1, "R6 stored at close");

    // R7: data toggles in the window, last sample stored (addr 3 holds 0)
    chipEnN = 1'b0; wrEnN = 1'b1; selAN = 1'b0; selBN = 1'b0; addr = 4'd3;
    tick();
    wrEnN = 1'b0; dataIn = 1'b1;
    tick();
    dataIn = 1'b0;
    tick();
    dataIn = 1'b1;
    tick();
    chipEnN = 1'b1; dataIn = 1'b0;
    tick();
    wrEnN = 1'b1; selAN = 1'b1; selBN = 1'b1;
    tick();
    readCycle(4'd3, 1'b1, "R7 last value stored");

    // R8: write enable held low across two strobe periods
    selAN = 1'b0; selBN = 1'b0; wrEnN = 1'b0;
    chipEnN = 1'b0; addr = 4'd7; dataIn = 1'b1;
    tick(); tick();
    chipEnN = 1'b1;
    tick();
    chipEnN = 1'b0; addr = 4'd8; dataIn = 1'b0;
    tick(); tick();
    chipEnN = 1'b1;
    tick();
    wrEnN = 1'b1; selAN = 1'b1; selBN = 1'b1;
    tick();
    readCycle(4'd7, 1'b1, "R8 first location");
    readCycle(4'd8, 1'b0, "R8 second location");

    // R11 / R9: combined read then write on addr 12 (holds 1)
    chipEnN = 1'b0; wrEnN = 1'b1; selAN = 1'b0; selBN = 1'b0; addr = 4'd12;
    tick(); tick();
    chk({31'b0, qOut}, 32'd1, "R11 old word before write");
    wrEnN = 1'b0; dataIn = 1'b0;
    tick();
    chk({31'b0, qEnable}, 32'd0, "R9 driver off on write enable");
    chipEnN = 1'b1;
    tick();
    chk({31'b0, qOut}, 32'd1, "R11 held old word after strobe rise");
    wrEnN = 1'b1; selAN = 1'b1; selBN = 1'b1;
    tick();
    readCycle(4'd12, 1'b0, "R11 new word stored");

    // R10: reset keeps array contents
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    chk({31'b0, qEnable}, 32'd0, "R10 driver off after reset");
    readCycle(4'd10, 1'b1, "R10 array kept");
    readCycle(4'd15, 1'b0, "R1 overwritten top word");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule